// File: doc/BRIEF.md
# Recirculating Multiply-Accumulate Ring

This block computes the product C = A x B of two signed fixed-point matrices on a chain of P multiply-accumulate elements. The last element feeds back into the first, so the chain forms a one-way ring. Each element owns two small local stores. One holds the A operands that it uses, and the other holds its B operands. The inner index k is split across the ring: element e handles every k with k mod P equal to e. A partial sum enters element 0 and collects one product in each element it passes through. When the inner dimension K is larger than P, the sum goes around the ring again for another pass. No memory ever holds an intermediate sum. Sums live only in the element stage registers.

The control logic takes output entries in groups of P, one group slot per cycle. A group circulates for K/P passes and then the next group enters. While the ring is full, every element performs one multiply-accumulate in every cycle. If the number of outputs M*N is not a multiple of P, the empty slots of the last group travel as bubbles. Software fills the local stores through a write port while the ring is idle, then issues a start pulse with M, N and K. Finished entries leave on a result port with their row and column.

Top module: `mac_ring`

## Requirements
- R1: Each result equals the sum over k < K of A[row][k]*B[k][col]. Operands are 16-bit two's complement and the sum is a 40-bit two's complement value with no saturation.
- R2: A write with wr_sel_i=0 stores into the A store of element wr_pe_i, and wr_sel_i=1 selects the B store. The A store of element e at address row*PASS_MAX+pass holds A[row][pass*P+e]. The B store at address pass*N_MAX+col holds B[pass*P+e][col].
- R3: A write issued while busy_o is high has no effect on any store.
- R4: start_i is accepted only while busy_o is low, and m_i, n_i and k_i are sampled on that edge. A start_i during a run is ignored and the run continues unchanged.
- R5: A run emits exactly M*N results, one per res_valid_o pulse, in row-major order. res_row_o and res_col_o give the entry index.
- R6: K must be a nonzero multiple of P. For K=P each sum makes one trip around the ring. For larger K the sum of the element P-1 stage returns to element 0 and takes K/P trips in total.
- R7: After reset busy_o and res_valid_o are low. busy_o is high from the edge that accepts start until the edge after the last result, and it is high whenever res_valid_o is high.
- R8: busy_o stays high for exactly G*(K/P)*P - (G*P - M*N) + P cycles per run, where G = ceil(M*N/P).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Local store write strobe |
| wr_pe_i | input | 2 | Target element index |
| wr_sel_i | input | 1 | 0 selects the A store, 1 selects the B store |
| wr_addr_i | input | 4 | Store address |
| wr_data_i | input | 16 | Signed operand to write |
| start_i | input | 1 | Run request pulse |
| m_i | input | 3 | Rows of A (1..M_MAX) |
| n_i | input | 3 | Columns of B (1..N_MAX) |
| k_i | input | 5 | Inner dimension, a multiple of P |
| busy_o | output | 1 | Run in progress |
| res_valid_o | output | 1 | Result strobe |
| res_row_o | output | 3 | Row of the result |
| res_col_o | output | 2 | Column of the result |
| res_data_o | output | 40 | Signed result sum |

## Verification
The bench targets runs where M*N leaves bubble slots in the last group. A design that emitted bubbles as results, or kept busy_o high for the whole padded group, would fail the result count and the busy-cycle check. Runs with several passes check that the sum returning from the last element joins the same slot. A skew of one cycle in the ring would mix sums from different entries. The bench also writes a store and raises start in the middle of a run. A block that accepted either one would corrupt the current results or the next run, or would cut the result count short. Full-scale negative operands show whether the products are sign-extended correctly into the 40-bit sum.

// File: rtl/mac_ring_pkg.sv
package mac_ring_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} ring_state_e;
endpackage

// File: rtl/mac_ring_pe.sv
module mac_ring_pe #(
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 40,
  parameter int A_DEPTH  = 16,
  parameter int B_DEPTH  = 16,
  parameter int ADDR_W   = 4,
  parameter int ROW_W    = 3,
  parameter int COL_W    = 2,
  parameter int PASS_W   = 2,
  parameter int PASS_MAX = 4,
  parameter int N_MAX    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     wr_sel_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic signed [DATA_W-1:0] wr_data_i,
  input  logic                     in_vld_i,
  input  logic                     in_last_i,
  input  logic [ROW_W-1:0]         in_row_i,
  input  logic [COL_W-1:0]         in_col_i,
  input  logic [PASS_W-1:0]        in_pass_i,
  input  logic signed [ACC_W-1:0]  in_sum_i,
  output logic                     out_vld_o,
  output logic                     out_last_o,
  output logic [ROW_W-1:0]         out_row_o,
  output logic [COL_W-1:0]         out_col_o,
  output logic [PASS_W-1:0]        out_pass_o,
  output logic signed [ACC_W-1:0]  out_sum_o
);
  localparam int AI_W = (A_DEPTH > 1) ? $clog2(A_DEPTH) : 1;
  localparam int BI_W = (B_DEPTH > 1) ? $clog2(B_DEPTH) : 1;

  logic signed [DATA_W-1:0]   a_mem [A_DEPTH];
  logic signed [DATA_W-1:0]   b_mem [B_DEPTH];
  logic [31:0]                a_idx, b_idx;
  logic signed [DATA_W-1:0]   a_op, b_op;
  logic signed [2*DATA_W-1:0] prod;

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !wr_sel_i && 32'(wr_addr_i) < A_DEPTH) a_mem[wr_addr_i[AI_W-1:0]] <= wr_data_i;
    if (wr_en_i &&  wr_sel_i && 32'(wr_addr_i) < B_DEPTH) b_mem[wr_addr_i[BI_W-1:0]] <= wr_data_i;
  end

  assign a_idx = 32'(in_row_i) * 32'(PASS_MAX) + 32'(in_pass_i);
  assign b_idx = 32'(in_pass_i) * 32'(N_MAX) + 32'(in_col_i);
  assign a_op  = (a_idx < 32'(A_DEPTH)) ? a_mem[a_idx[AI_W-1:0]] : '0;
  assign b_op  = (b_idx < 32'(B_DEPTH)) ? b_mem[b_idx[BI_W-1:0]] : '0;
  assign prod  = a_op * b_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o  <= 1'b0;
      out_last_o <= 1'b0;
      out_row_o  <= '0;
      out_col_o  <= '0;
      out_pass_o <= '0;
      out_sum_o  <= '0;
    end else begin
      out_vld_o  <= in_vld_i;
      out_last_o <= in_last_i;
      out_row_o  <= in_row_i;
      out_col_o  <= in_col_i;
      out_pass_o <= in_pass_i;
      out_sum_o  <= in_sum_i + ACC_W'(prod);
    end
  end

  // one stage per element: a slot keeps its identity across the stage
  assert_stage_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i |=> (out_vld_o && out_row_o == $past(in_row_i) && out_col_o == $past(in_col_i)));
endmodule

// File: rtl/mac_ring_ctrl.sv
module mac_ring_ctrl import mac_ring_pkg::*; #(
  parameter int P      = 4,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int NW     = 3,
  parameter int PASS_W = 2,
  parameter int KW     = 5,
  parameter int SLOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [ROW_W-1:0]  m_i,
  input  logic [NW-1:0]     n_i,
  input  logic [KW-1:0]     k_i,
  output logic              run_o,
  output logic              tok_vld_o,
  output logic              tok_first_o,
  output logic              tok_last_o,
  output logic [ROW_W-1:0]  tok_row_o,
  output logic [COL_W-1:0]  tok_col_o,
  output logic [PASS_W-1:0] tok_pass_o
);
  ring_state_e       state_q;
  logic [ROW_W-1:0]  m_q, base_row_q, cur_row_q, row_n;
  logic [NW-1:0]     n_q;
  logic [COL_W-1:0]  base_col_q, cur_col_q, col_n;
  logic [PASS_W:0]   np_q;
  logic [PASS_W-1:0] pass_q;
  logic [SLOT_W-1:0] slot_q;
  logic              last_pass;

  assign last_pass = ({1'b0, pass_q} == np_q - 1'b1);

  // next output index in row-major order; frozen once past the last row
  always_comb begin
    row_n = cur_row_q;
    col_n = cur_col_q;
    if (cur_row_q < m_q) begin
      if (NW'(cur_col_q) == n_q - NW'(1)) begin
        col_n = '0;
        row_n = cur_row_q + ROW_W'(1);
      end else begin
        col_n = cur_col_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      m_q        <= '0;
      n_q        <= '0;
      np_q       <= '0;
      base_row_q <= '0;
      base_col_q <= '0;
      cur_row_q  <= '0;
      cur_col_q  <= '0;
      pass_q     <= '0;
      slot_q     <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i && !busy_i) begin
        state_q    <= ST_RUN;
        m_q        <= m_i;
        n_q        <= n_i;
        np_q       <= (PASS_W+1)'(k_i / KW'(P));
        base_row_q <= '0;
        base_col_q <= '0;
        cur_row_q  <= '0;
        cur_col_q  <= '0;
        pass_q     <= '0;
        slot_q     <= '0;
      end
    end else begin
      if (slot_q == SLOT_W'(P - 1)) begin
        slot_q <= '0;
        if (last_pass) begin
          pass_q     <= '0;
          base_row_q <= row_n;
          base_col_q <= col_n;
          cur_row_q  <= row_n;
          cur_col_q  <= col_n;
          if (row_n >= m_q) state_q <= ST_IDLE;
        end else begin
          pass_q    <= pass_q + PASS_W'(1);
          cur_row_q <= base_row_q;
          cur_col_q <= base_col_q;
        end
      end else begin
        slot_q    <= slot_q + SLOT_W'(1);
        cur_row_q <= row_n;
        cur_col_q <= col_n;
      end
    end
  end

  assign run_o       = (state_q == ST_RUN);
  assign tok_vld_o   = run_o && (cur_row_q < m_q);
  assign tok_first_o = (pass_q == '0);
  assign tok_last_o  = last_pass;
  assign tok_row_o   = cur_row_q;
  assign tok_col_o   = cur_col_q;
  assign tok_pass_o  = pass_q;

  assert_start_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_i) |=> ($stable(m_q) && $stable(n_q) && $stable(np_q)));
endmodule

// File: rtl/mac_ring.sv
module mac_ring #(
  parameter int P        = 4,
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 40,
  parameter int M_MAX    = 4,
  parameter int N_MAX    = 4,
  parameter int PASS_MAX = 4,
  localparam int A_DEPTH = M_MAX * PASS_MAX,
  localparam int B_DEPTH = PASS_MAX * N_MAX,
  localparam int ADDR_W  = $clog2((A_DEPTH > B_DEPTH) ? A_DEPTH : B_DEPTH),
  localparam int ROW_W   = $clog2(M_MAX + 1),
  localparam int COL_W   = (N_MAX > 1) ? $clog2(N_MAX) : 1,
  localparam int NW      = $clog2(N_MAX + 1),
  localparam int PASS_W  = (PASS_MAX > 1) ? $clog2(PASS_MAX) : 1,
  localparam int KW      = $clog2(P * PASS_MAX + 1),
  localparam int PE_W    = (P > 1) ? $clog2(P) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [PE_W-1:0]         wr_pe_i,
  input  logic                    wr_sel_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    start_i,
  input  logic [ROW_W-1:0]        m_i,
  input  logic [NW-1:0]           n_i,
  input  logic [KW-1:0]           k_i,
  output logic                    busy_o,
  output logic                    res_valid_o,
  output logic [ROW_W-1:0]        res_row_o,
  output logic [COL_W-1:0]        res_col_o,
  output logic [ACC_W-1:0]        res_data_o
);
  logic              run, tok_vld, tok_first, tok_last;
  logic [ROW_W-1:0]  tok_row;
  logic [COL_W-1:0]  tok_col;
  logic [PASS_W-1:0] tok_pass;

  logic                    in_vld  [P];
  logic                    in_last [P];
  logic [ROW_W-1:0]        in_row  [P];
  logic [COL_W-1:0]        in_col  [P];
  logic [PASS_W-1:0]       in_pass [P];
  logic signed [ACC_W-1:0] in_sum  [P];
  logic                    st_vld  [P];
  logic                    st_last [P];
  logic [ROW_W-1:0]        st_row  [P];
  logic [COL_W-1:0]        st_col  [P];
  logic [PASS_W-1:0]       st_pass [P];
  logic signed [ACC_W-1:0] st_sum  [P];
  logic [P-1:0]            vld_vec;

  mac_ring_ctrl #(
    .P(P), .ROW_W(ROW_W), .COL_W(COL_W), .NW(NW), .PASS_W(PASS_W), .KW(KW), .SLOT_W(PE_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .busy_i(busy_o), .m_i, .n_i, .k_i,
    .run_o(run), .tok_vld_o(tok_vld), .tok_first_o(tok_first), .tok_last_o(tok_last),
    .tok_row_o(tok_row), .tok_col_o(tok_col), .tok_pass_o(tok_pass)
  );

  for (genvar e = 0; e < P; e++) begin : g_pe
    if (e == 0) begin : g_head
      // fresh zero on the first pass, otherwise the sum returning from the tail
      assign in_vld[0]  = tok_vld;
      assign in_last[0] = tok_last;
      assign in_row[0]  = tok_row;
      assign in_col[0]  = tok_col;
      assign in_pass[0] = tok_pass;
      assign in_sum[0]  = tok_first ? '0 : st_sum[P-1];
    end else begin : g_body
      assign in_vld[e]  = st_vld[e-1];
      assign in_last[e] = st_last[e-1];
      assign in_row[e]  = st_row[e-1];
      assign in_col[e]  = st_col[e-1];
      assign in_pass[e] = st_pass[e-1];
      assign in_sum[e]  = st_sum[e-1];
    end

    mac_ring_pe #(
      .DATA_W(DATA_W), .ACC_W(ACC_W), .A_DEPTH(A_DEPTH), .B_DEPTH(B_DEPTH), .ADDR_W(ADDR_W),
      .ROW_W(ROW_W), .COL_W(COL_W), .PASS_W(PASS_W), .PASS_MAX(PASS_MAX), .N_MAX(N_MAX)
    ) u_pe (
      .clk_i, .rst_ni,
      .wr_en_i(wr_en_i && !busy_o && wr_pe_i == PE_W'(e)),
      .wr_sel_i, .wr_addr_i, .wr_data_i(signed'(wr_data_i)),
      .in_vld_i(in_vld[e]), .in_last_i(in_last[e]), .in_row_i(in_row[e]),
      .in_col_i(in_col[e]), .in_pass_i(in_pass[e]), .in_sum_i(in_sum[e]),
      .out_vld_o(st_vld[e]), .out_last_o(st_last[e]), .out_row_o(st_row[e]),
      .out_col_o(st_col[e]), .out_pass_o(st_pass[e]), .out_sum_o(st_sum[e])
    );
    assign vld_vec[e] = st_vld[e];
  end

  assign busy_o      = run || (|vld_vec);
  assign res_valid_o = st_vld[P-1] && st_last[P-1];
  assign res_row_o   = st_row[P-1];
  assign res_col_o   = st_col[P-1];
  assign res_data_o  = st_sum[P-1];

  assert_recirc_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_vld && !tok_first) |-> (st_vld[P-1] && st_row[P-1] == tok_row &&
                                 st_col[P-1] == tok_col && st_pass[P-1] == tok_pass - PASS_W'(1)));
  assert_res_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> busy_o);
  assert_busy_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(res_valid_o));
endmodule

// File: tb/mac_ring_bench.sv
module mac_ring_bench;
  localparam int P = 4, M_MAX = 4, N_MAX = 4, PASS_MAX = 4, K_MAX = P * PASS_MAX;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0, start_i = 1'b0;
  logic [1:0]  wr_pe_i = '0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  m_i = '0, n_i = '0;
  logic [4:0]  k_i = '0;
  logic        busy_o, res_valid_o;
  logic [2:0]  res_row_o;
  logic [1:0]  res_col_o;
  logic [39:0] res_data_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int a_m [M_MAX][K_MAX];
  int b_m [K_MAX][N_MAX];

  always #2 clk = ~clk;

  mac_ring u_mac_ring (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_pe_i, .wr_sel_i, .wr_addr_i, .wr_data_i,
    .start_i, .m_i, .n_i, .k_i, .busy_o, .res_valid_o, .res_row_o, .res_col_o, .res_data_o
  );

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2 layout: A store addr row*PASS_MAX+pass, B store addr pass*N_MAX+col
  task automatic load_all();
    for (int e = 0; e < P; e++)
      for (int p = 0; p < PASS_MAX; p++) begin
        for (int r = 0; r < M_MAX; r++) begin
          @(negedge clk);
          wr_en_i = 1; wr_pe_i = 2'(e); wr_sel_i = 0;
          wr_addr_i = 4'(r * PASS_MAX + p); wr_data_i = 16'(a_m[r][p*P+e]);
        end
        for (int c = 0; c < N_MAX; c++) begin
          @(negedge clk);
          wr_en_i = 1; wr_pe_i = 2'(e); wr_sel_i = 1;
          wr_addr_i = 4'(p * N_MAX + c); wr_data_i = 16'(b_m[p*P+e][c]);
        end
      end
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic fill_rand();
    for (int r = 0; r < M_MAX; r++)
      for (int k = 0; k < K_MAX; k++) a_m[r][k] = int'($urandom_range(65535)) - 32768;
    for (int k = 0; k < K_MAX; k++)
      for (int c = 0; c < N_MAX; c++) b_m[k][c] = int'($urandom_range(65535)) - 32768;
  endtask

  function automatic longint dot(int r, int c, int k);
    longint s = 0;
    for (int i = 0; i < k; i++) s += longint'(a_m[r][i]) * longint'(b_m[i][c]);
    return s;
  endfunction

  task automatic run(int m, int n, int k, bit poke_wr, bit poke_start);
    int got = 0, busy_cyc = 0, grp, pad, exp_cyc;
    grp = (m * n + P - 1) / P;
    pad = grp * P - m * n;
    exp_cyc = grp * (k / P) * P - pad + P;
    @(negedge clk);
    m_i = 3'(m); n_i = 3'(n); k_i = 5'(k); start_i = 1;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      @(negedge clk);
      start_i = 0; wr_en_i = 0;
      if (cyc == 1 && poke_wr) begin
        wr_en_i = 1; wr_pe_i = 0; wr_sel_i = 0; wr_addr_i = 0; wr_data_i = 16'h1234;
      end
      if (cyc == 1 && poke_start) begin
        start_i = 1; m_i = 3'd1; n_i = 3'd1; k_i = 5'(P);
      end
      if (res_valid_o) begin
        if (got < m * n) begin
          check("R5 row", longint'(res_row_o), longint'(got / n));
          check("R5 col", longint'(res_col_o), longint'(got % n));
          check(k > P ? "R1 R2 R6 sum multi-pass" : "R1 R2 R6 sum single-pass",
                longint'($signed(res_data_o)), dot(got / n, got % n, k));
        end
        got++;
      end
      if (busy_o) busy_cyc++;
      else break;
    end
    check(poke_start ? "R4 R5 result count" : "R5 result count", longint'(got), longint'(m * n));
    check("R8 busy cycles", longint'(busy_cyc), longint'(exp_cyc));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R7 reset busy", longint'(busy_o), 0);
    check("R7 reset valid", longint'(res_valid_o), 0);
    rst_ni = 1;

    fill_rand();
    load_all();
    run(4, 4, 16, 0, 0);
    run(1, 1, 4, 0, 0);
    run(3, 2, 8, 0, 0);
    // R3: write during the run must not land; rerun without reload
    run(4, 4, 4, 1, 0);
    run(4, 4, 4, 0, 0);
    run(2, 3, 12, 0, 1);

    // full-scale operands: sign extension into the 40-bit sum
    for (int r = 0; r < M_MAX; r++) for (int k = 0; k < K_MAX; k++) a_m[r][k] = -32768;
    for (int k = 0; k < K_MAX; k++) for (int c = 0; c < N_MAX; c++) b_m[k][c] = -32768;
    load_all();
    run(1, 1, 16, 0, 0);
    for (int k = 0; k < K_MAX; k++) for (int c = 0; c < N_MAX; c++) b_m[k][c] = 32767;
    load_all();
    run(2, 2, 16, 0, 0);

    for (int t = 0; t < 6; t++) begin
      fill_rand();
      load_all();
      run(int'($urandom_range(M_MAX, 1)), int'($urandom_range(N_MAX, 1)),
          P * int'($urandom_range(PASS_MAX, 1)), 0, 0);
    end

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule